// File: doc/BRIEF.md
# Two-Channel Buffered DAC Command Decoder

This block takes 16-bit command words that a serial front end has already received and marked for execution, and drives the digital codes of a two-channel 10-bit converter. Each channel has two register stages: a staging register that commands can write quietly, and an active register whose value appears at the block's outputs. One command writes both stages of both channels at once. Two others write only one channel's staging register, leaving every output as it was.

A separate active-low transfer strobe copies both staging registers into the active registers together. This lets a controller stage new codes on several converters and then change all their outputs at the same moment. The strobe is asynchronous to the clock, so it is synchronized first. A transfer happens once for each falling edge, however long the strobe stays low.

Top module: `dac_cmd_decoder`

## Requirements
- R1: While reset is asserted and after it is released, both outputs and both staging registers hold midscale (0x200).
- R2: The control code sits in word bits [15:13] and the 10-bit data in bits [12:3]. Bits [2:0] have no effect on any register.
- R3: An executed word with control 3'b011 writes its data into both staging and both active registers. Both outputs show the data one clock after the command.
- R4: Control 3'b001 writes the data into staging register A only. Neither output changes.
- R5: Control 3'b101 writes the data into staging register B only. Neither output changes.
- R6: The all-zero word and every control code other than 011, 001 and 101 change no register.
- R7: A falling edge on xfer_n copies staging A into active A and staging B into active B. The outputs change at the third rising clock edge at which xfer_n is sampled low, counting from the first such edge, and not before.
- R8: Holding xfer_n low causes exactly one transfer. A staging write made while it stays low reaches the outputs only at the next falling edge.
- R9: While cmd_valid is low, cmd_word has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | One-cycle strobe: execute cmd_word |
| cmd_word | input | 16 | Command word: control, data, unused bits |
| xfer_n | input | 1 | Asynchronous active-low staging-to-active transfer strobe |
| dac_a | output | 10 | Active code of channel A |
| dac_b | output | 10 | Active code of channel B |

## Verification
On every cycle, the assertions check three things: the midscale reset values, the one-cycle result of a load-all command, and that the outputs stay put whenever no load-all command arrives and no strobe edge is pending. A further assertion checks what a detected transfer copies. The stage-only commands are invisible at the outputs, so only the bench's scenarios can show their effect. It strobes a transfer afterwards and reads which staging value arrives. The bench scenarios also show the exact synchronizer latency, the single transfer for a held strobe, and that the ignored bits and unlisted codes leave the registers alone.

// File: rtl/dac_cmd_decoder.sv
module dac_cmd_decoder #(
  parameter int DATA_W = 10,
  parameter int CMD_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [CMD_W-1:0]  cmd_word,
  input  logic              xfer_n,
  output logic [DATA_W-1:0] dac_a,
  output logic [DATA_W-1:0] dac_b
);
  localparam int CTRL_LSB = CMD_W - 3;
  localparam int DATA_LSB = CTRL_LSB - DATA_W;
  localparam logic [DATA_W-1:0] MID = DATA_W'(1) << (DATA_W - 1);

  logic [2:0]        ctrl;
  logic [DATA_W-1:0] data;
  logic [DATA_W-1:0] stage_a, stage_b;
  logic [2:0]        sync;
  logic              xfer;
  logic              ld_all, ld_a, ld_b;

  assign ctrl   = cmd_word[CMD_W-1:CTRL_LSB];
  assign data   = cmd_word[CTRL_LSB-1:DATA_LSB];
  assign ld_all = cmd_valid && ctrl == 3'b011;
  assign ld_a   = cmd_valid && ctrl == 3'b001;
  assign ld_b   = cmd_valid && ctrl == 3'b101;
  assign xfer   = sync[2] && !sync[1];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) sync <= '1;
    else        sync <= {sync[1:0], xfer_n};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      stage_a <= MID;
      stage_b <= MID;
    end else begin
      if (ld_all || ld_a) stage_a <= data;
      if (ld_all || ld_b) stage_b <= data;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      dac_a <= MID;
      dac_b <= MID;
    end else if (ld_all) begin
      dac_a <= data;
      dac_b <= data;
    end else if (xfer) begin
      dac_a <= stage_a;
      dac_b <= stage_b;
    end
endmodule

// File: rtl/dac_cmd_decoder_chk.sv
module dac_cmd_decoder_chk #(
  parameter int DATA_W = 10,
  parameter int CMD_W  = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_valid,
  input logic [CMD_W-1:0]  cmd_word,
  input logic              xfer_n,
  input logic [DATA_W-1:0] dac_a,
  input logic [DATA_W-1:0] dac_b,
  input logic [DATA_W-1:0] stage_a,
  input logic [DATA_W-1:0] stage_b,
  input logic              xfer
);
  localparam logic [DATA_W-1:0] MID = DATA_W'(1) << (DATA_W - 1);
  logic load_all;
  assign load_all = cmd_valid && cmd_word[CMD_W-1:CMD_W-3] == 3'b011;

  // R1
  reset_mid_chk: assert property (@(posedge clk)
    !rst_n |=> dac_a == MID && dac_b == MID);

  // R3
  load_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_all |=> dac_a == $past(cmd_word[CMD_W-4 -: DATA_W]) &&
                 dac_b == $past(cmd_word[CMD_W-4 -: DATA_W]));

  // R4
  quiet_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_n && $past(xfer_n) && $past(xfer_n, 2) && !load_all)
      |=> $stable(dac_a) && $stable(dac_b));

  // R7
  xfer_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer && !load_all) |=> dac_a == $past(stage_a) && dac_b == $past(stage_b));
endmodule

bind dac_cmd_decoder dac_cmd_decoder_chk #(.DATA_W(DATA_W), .CMD_W(CMD_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_word(cmd_word),
  .xfer_n(xfer_n), .dac_a(dac_a), .dac_b(dac_b),
  .stage_a(stage_a), .stage_b(stage_b), .xfer(xfer)
);

// File: tb/sim_dac_cmd_decoder.sv
module sim_dac_cmd_decoder;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        cmd_valid = 0;
  logic [15:0] cmd_word = 0;
  logic        xfer_n = 1;
  logic [9:0]  dac_a, dac_b;
  int checks = 0, failures = 0;
  logic [9:0] ea, eb, sa, sb;

  always #4 clk = ~clk;

  dac_cmd_decoder u0 (.clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid),
    .cmd_word(cmd_word), .xfer_n(xfer_n), .dac_a(dac_a), .dac_b(dac_b));

  task automatic chk(string req, logic [9:0] a, logic [9:0] b);
    checks++;
    if (dac_a !== a || dac_b !== b) begin
      failures++;
      $display("FAIL %s: a=%h b=%h expected a=%h b=%h", req, dac_a, dac_b, a, b);
    end
  endtask

  task automatic send(logic [2:0] c, logic [9:0] d, logic [2:0] junk, logic v = 1);
    @(negedge clk);
    cmd_word = {c, d, junk}; cmd_valid = v;
    @(negedge clk);
    cmd_valid = 0; cmd_word = $urandom;
    if (v) begin
      if (c == 3'b011) begin sa = d; sb = d; ea = d; eb = d; end
      else if (c == 3'b001) sa = d;
      else if (c == 3'b101) sb = d;
    end
  endtask

  task automatic pulse(string req);
    @(negedge clk); xfer_n = 0;
    @(negedge clk); @(negedge clk);
    chk(req, ea, eb);
    @(negedge clk);
    ea = sa; eb = sb;
    chk(req, ea, eb);
    xfer_n = 1;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    #4_000_000;
    failures++;
    $display("FAIL watchdog: expected completion, got timeout");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    ea = 10'h200; eb = 10'h200; sa = 10'h200; sb = 10'h200;
    repeat (3) @(negedge clk);
    chk("R1", 10'h200, 10'h200);
    rst_n = 1;
    repeat (2) @(negedge clk);
    chk("R1", 10'h200, 10'h200);
    pulse("R1 staging midscale");

    for (int d = 0; d < 1024; d++) begin
      send(3'b011, 10'(d), 3'(d * 5));
      chk("R3 R2", ea, eb);
    end

    for (int d = 3; d < 1024; d += 97) begin
      send(3'b001, 10'(d), 3'b111);
      chk("R4", ea, eb);
      send(3'b101, 10'(1023 - d), 3'b010);
      chk("R5", ea, eb);
      pulse("R7");
    end

    for (int c = 0; c < 8; c++) begin
      if (c == 1 || c == 3 || c == 5) continue;
      send(3'(c), 10'(c * 111 + 7), 3'(c));
      chk("R6", ea, eb);
    end
    send(3'b000, 10'h000, 3'b000);
    chk("R6 zero word", ea, eb);
    pulse("R6 staging kept");

    send(3'b011, 10'h155, 3'b000, 0);
    send(3'b001, 10'h0AA, 3'b000, 0);
    chk("R9", ea, eb);
    pulse("R9 staging kept");

    send(3'b001, 10'h3C3, 3'b000);
    send(3'b101, 10'h03C, 3'b000);
    @(negedge clk); xfer_n = 0;
    repeat (3) @(negedge clk);
    ea = sa; eb = sb;
    chk("R8 first transfer", ea, eb);
    send(3'b001, 10'h111, 3'b000);
    send(3'b101, 10'h222, 3'b000);
    repeat (6) @(negedge clk);
    chk("R8 held low", ea, eb);
    xfer_n = 1;
    repeat (4) @(negedge clk);
    chk("R8 released", ea, eb);
    pulse("R8 next edge");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule